// File: doc/BRIEF.md
# Page Write Buffer and Commit

This unit collects the data bytes of a two-wire serial write transfer into a page-sized staging buffer. It then copies them to a byte-wide memory port as one timed internal write cycle. A protocol engine in front of it supplies four events: the start of a write transfer carrying the full word address, one strobe per received data byte, the stop that ends the transfer, and a repeated start that abandons it. The unit keeps the word pointer. The page number comes from the address loaded at transfer start. The position inside the page advances by one for each byte and wraps at the page end, so surplus bytes replace earlier ones and never cross into the next page.

A stop that follows at least one buffered byte, while write protect is low, starts the write cycle. During the cycle `busy` is high, and every slot that was loaded is written to memory once, in ascending slot order, one slot per clock. `busy` stays high for a parameterised number of clocks. While it is high the protocol engine refuses new requests, and this unit ignores every event it receives. If write protect is high at the stop, the bytes are still taken and the pointer still moves, but no cycle starts. A repeated start discards the buffer. The pointer it leaves behind serves a following read.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are 0 and `ptr_addr` is 0.
- R2: When `xfer_begin` is accepted (busy low), `ptr_addr` equals `word_addr` on the next cycle. The page base is that address with its low log2(PAGE_BYTES) bits cleared. All buffer slots become unloaded.
- R3: During a transfer, each `byte_stb` stores `byte_data` in the slot selected by the low bits of `ptr_addr`. It also advances those low bits by one, modulo PAGE_BYTES, and leaves the page bits unchanged.
- R4: When more than PAGE_BYTES bytes arrive before the stop, the offset wraps to the page start. Each slot commits only the last byte stored in it.
- R5: During the write cycle, each loaded slot is written exactly once and no unloaded slot is written. Writes go in ascending slot order, at `mem_addr` = page base + slot index (the page bits in the upper field, the slot index in the low bits).
- R6: A stop with write protect low and at least one loaded slot raises `busy` on the next cycle. `busy` then stays high for max(WR_CYCLES, PAGE_BYTES) consecutive cycles.
- R7: While `busy` is high, `xfer_begin`, `byte_stb`, `bus_stop` and `bus_restart` have no effect on `ptr_addr`, the buffer, or the length of the cycle. `byte_stb` and `bus_stop` outside a transfer are likewise ignored.
- R8: If `wp` is high in the cycle `bus_stop` is taken, no write cycle starts: `busy` and `mem_we` stay 0.
- R9: A `bus_restart` during a transfer ends it without any write cycle.
- R10: After the transfer, `ptr_addr` holds the page base plus ((start offset + byte count) mod PAGE_BYTES), whether or not a cycle ran.
- R11: A stop after a transfer that carried no data byte starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_begin | input | 1 | Write transfer starts; address in `word_addr` |
| word_addr | input | ADDR_W | Word address of the transfer |
| byte_stb | input | 1 | One data byte received and acknowledged |
| byte_data | input | 8 | Received data byte |
| bus_stop | input | 1 | Stop condition ended the transfer |
| bus_restart | input | 1 | Repeated start ended the transfer |
| wp | input | 1 | Write protect, sampled with the stop |
| busy | output | 1 | Internal write cycle in progress |
| ptr_addr | output | ADDR_W | Current word pointer |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
Several properties hold on every cycle and are checked that way: memory strobes appear only inside a write cycle, the page field of the write address is constant for the whole cycle, a cycle begins only after an unprotected stop, the pointer is frozen while busy, the page bits never move without a transfer start, and a repeated start never leads to a cycle. Other properties need whole transfers with known contents, and only the bench scenarios can show them: which slots get written and with what data after a wrap, the exact cycle length, and the final pointer value. The bench sweeps every start offset against byte counts from zero to beyond two pages, and adds protected, abandoned and busy-time-intrusion transfers.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILL = 2'd1,
    PH_BURN = 2'd2
  } phase_e;
endpackage

// File: rtl/pgbuf_pointer.sv
module pgbuf_pointer #(
  parameter int ADDR_W = 15,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [OFF_W-1:0]  off_inc;
  logic              ptr_en;

  // offset wraps inside the page; page bits are untouched by a step
  assign off_inc = ptr_q[OFF_W-1:0] + {{(OFF_W-1){1'b0}}, 1'b1};
  assign ptr_en  = load | step;

  always_comb begin
    ptr_d = ptr_q;
    if (load)      ptr_d = load_addr;
    else if (step) ptr_d = {ptr_q[ADDR_W-1:OFF_W], off_inc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/pgbuf_slots.sv
module pgbuf_slots #(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [OFF_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [PAGE_BYTES-1:0] loaded
);
  logic [PAGE_BYTES-1:0][7:0] data_all;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : slot_g
    logic       hit;
    logic       vld_q, vld_d, vld_en;
    logic [7:0] byte_q;

    assign hit    = wr_en && (wr_idx == OFF_W'(g));
    assign vld_en = clr | hit;

    always_comb begin
      vld_d = vld_q;
      if (clr)      vld_d = 1'b0;
      else if (hit) vld_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      vld_q <= 1'b0;
      else if (vld_en) vld_q <= vld_d;
    end

    // data needs no reset: the valid bit qualifies it
    always_ff @(posedge clk) begin
      if (hit) byte_q <= wr_data;
    end

    assign loaded[g]   = vld_q;
    assign data_all[g] = byte_q;
  end

  assign rd_data = data_all[rd_idx];
endmodule

// File: rtl/pgbuf_sequencer.sv
module pgbuf_sequencer
  import pgbuf_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int OFF_W      = 6,
  parameter int WR_CYCLES  = 1000,
  localparam int SPAN      = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES,
  localparam int CNT_W     = $clog2(SPAN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             begin_req,
  input  logic             byte_req,
  input  logic             stop_req,
  input  logic             restart_req,
  input  logic             wp,
  input  logic             any_loaded,
  output logic             take_begin,
  output logic             take_byte,
  output logic             drop_buf,
  output logic             busy,
  output logic             scan_go,
  output logic [OFF_W-1:0] scan_idx
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign take_begin = begin_req && (ph_q != PH_BURN);
  assign take_byte  = byte_req && (ph_q == PH_FILL) && !begin_req;
  assign drop_buf   = take_begin || ((ph_q == PH_FILL) && restart_req);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (begin_req) ph_d = PH_FILL;
      end
      PH_FILL: begin
        if (begin_req) begin
          ph_d = PH_FILL;
        end else if (stop_req) begin
          if (!wp && any_loaded) begin
            ph_d   = PH_BURN;
            cnt_d  = '0;
            cnt_en = 1'b1;
          end else begin
            ph_d = PH_IDLE;
          end
        end else if (restart_req) begin
          ph_d = PH_IDLE;
        end
      end
      PH_BURN: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
        if (cnt_q == CNT_W'(SPAN - 1)) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy     = (ph_q == PH_BURN);
  assign scan_go  = busy && (cnt_q < CNT_W'(PAGE_BYTES));
  assign scan_idx = cnt_q[OFF_W-1:0];
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int WR_CYCLES  = 1000,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_begin,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              byte_stb,
  input  logic [7:0]        byte_data,
  input  logic              bus_stop,
  input  logic              bus_restart,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic                  take_begin, take_byte, drop_buf, scan_go;
  logic [OFF_W-1:0]      scan_idx;
  logic [PAGE_BYTES-1:0] loaded;
  logic [7:0]            rd_data;

  pgbuf_sequencer #(
    .PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .begin_req(xfer_begin), .byte_req(byte_stb), .stop_req(bus_stop),
    .restart_req(bus_restart), .wp(wp), .any_loaded(|loaded),
    .take_begin(take_begin), .take_byte(take_byte), .drop_buf(drop_buf),
    .busy(busy), .scan_go(scan_go), .scan_idx(scan_idx)
  );

  pgbuf_pointer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .load(take_begin), .load_addr(word_addr), .step(take_byte),
    .ptr(ptr_addr)
  );

  pgbuf_slots #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .clr(drop_buf), .wr_en(take_byte), .wr_idx(ptr_addr[OFF_W-1:0]),
    .wr_data(byte_data), .rd_idx(scan_idx), .rd_data(rd_data),
    .loaded(loaded)
  );

  assign mem_we    = scan_go && loaded[scan_idx];
  assign mem_addr  = {ptr_addr[ADDR_W-1:OFF_W], scan_idx};
  assign mem_wdata = rd_data;
endmodule

// File: rtl/pgbuf_checker.sv
module pgbuf_checker #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_begin,
  input logic [ADDR_W-1:0] word_addr,
  input logic              bus_stop,
  input logic              bus_restart,
  input logic              wp,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr_addr,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_we_inside_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));

  assert_cycle_needs_open_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(bus_stop) && !$past(wp)));

  assert_frozen_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ptr_addr));

  assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stop && wp && !busy) |=> !busy);

  assert_restart_no_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_restart && !bus_stop && !busy) |=> !busy);

  assert_load_pointer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_begin && !busy) |=> (ptr_addr == $past(word_addr)));

  assert_page_bits_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_begin |=> $stable(ptr_addr[ADDR_W-1:OFF_W]));
endmodule

bind pgbuf_commit pgbuf_checker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_pgbuf_chk (
  .clk(clk), .rst_n(rst_n), .xfer_begin(xfer_begin), .word_addr(word_addr),
  .bus_stop(bus_stop), .bus_restart(bus_restart), .wp(wp), .busy(busy),
  .ptr_addr(ptr_addr), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/test_pgbuf_commit.sv
module test_pgbuf_commit;
  localparam int AW  = 8;
  localparam int PG  = 8;
  localparam int OW  = 3;
  localparam int WRC = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_begin, byte_stb, bus_stop, bus_restart, wp;
  logic [AW-1:0] word_addr;
  logic [7:0]    byte_data;
  logic          busy, mem_we;
  logic [AW-1:0] ptr_addr, mem_addr;
  logic [7:0]    mem_wdata;

  always #4 clk = ~clk;

  pgbuf_commit #(.ADDR_W(AW), .PAGE_BYTES(PG), .WR_CYCLES(WRC)) i_pgbuf_commit (
    .clk(clk), .rst_n(rst_n), .xfer_begin(xfer_begin), .word_addr(word_addr),
    .byte_stb(byte_stb), .byte_data(byte_data), .bus_stop(bus_stop),
    .bus_restart(bus_restart), .wp(wp), .busy(busy), .ptr_addr(ptr_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write monitor
  int         busy_cnt, wr_total, order_bad, page_bad, last_slot;
  int         hit_cnt [PG];
  logic [7:0] cap [PG];
  int         exp_page;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
        int s;
        s = int'(mem_addr[OW-1:0]);
        hit_cnt[s]++;
        cap[s] = mem_wdata;
        wr_total++;
        if (s <= last_slot) order_bad++;
        last_slot = s;
        if (int'(mem_addr[AW-1:OW]) != exp_page) page_bad++;
      end
    end
  end

  task automatic clear_mon(input int page);
    busy_cnt = 0; wr_total = 0; order_bad = 0; page_bad = 0; last_slot = -1;
    exp_page = page;
    for (int k = 0; k < PG; k++) begin hit_cnt[k] = 0; cap[k] = 8'h00; end
  endtask

  task automatic pulse_begin(input logic [AW-1:0] a);
    @(negedge clk); xfer_begin = 1'b1; word_addr = a;
    @(negedge clk); xfer_begin = 1'b0;
  endtask

  task automatic pulse_byte(input logic [7:0] d);
    @(negedge clk); byte_stb = 1'b1; byte_data = d;
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic pulse_end(input bit restart, input bit wpv);
    @(negedge clk); wp = wpv;
    if (restart) bus_restart = 1'b1; else bus_stop = 1'b1;
    @(negedge clk); bus_restart = 1'b0; bus_stop = 1'b0; wp = 1'b0;
  endtask

  task automatic run(input int start, input int n, input bit wpv, input bit restart);
    bit         ev [PG];
    logic [7:0] ed [PG];
    bit         commit;
    int         endp;
    string      tag;
    for (int k = 0; k < PG; k++) begin ev[k] = 1'b0; ed[k] = 8'h00; end
    clear_mon(start / PG);
    pulse_begin(AW'(start));
    chk("R2 pointer load", int'(ptr_addr), start);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      int         s;
      d = 8'((start * 37 + n * 11 + i * 5 + 1) & 255);
      s = (start + i) % PG;
      ev[s] = 1'b1; ed[s] = d;
      pulse_byte(d);
    end
    endp = (start / PG) * PG + (start % PG + n) % PG;
    chk("R3 pointer advance", int'(ptr_addr), endp);
    pulse_end(restart, wpv);
    repeat (WRC + 4) @(negedge clk);
    commit = !restart && !wpv && (n > 0);
    if (restart)      tag = "R9 restart";
    else if (wpv)     tag = "R8 protect";
    else if (n == 0)  tag = "R11 empty";
    else              tag = "R6 busy length";
    chk(tag, busy_cnt, commit ? WRC : 0);
    for (int k = 0; k < PG; k++) begin
      chk("R5 slot written", hit_cnt[k], (commit && ev[k]) ? 1 : 0);
      if (commit && ev[k])
        chk(n > PG ? "R4 wrap data" : "R5 slot data", int'(cap[k]), int'(ed[k]));
    end
    chk("R5 order/page", order_bad + page_bad, 0);
    chk("R10 final pointer", int'(ptr_addr), endp);
  endtask

  initial begin
    rst_n = 1'b0; xfer_begin = 1'b0; byte_stb = 1'b0; bus_stop = 1'b0;
    bus_restart = 1'b0; wp = 1'b0; word_addr = '0; byte_data = '0;
    clear_mon(0);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 mem_we", int'(mem_we), 0);
    chk("R1 ptr", int'(ptr_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep start offset against byte count (0 .. beyond two pages)
    for (int off = 0; off < PG; off++)
      for (int n = 0; n <= 2 * PG + 1; n++)
        run(((off * 3 + n) % 32) * PG + off, n, 1'b0, 1'b0);

    // write protect at stop
    run(8'h2D, 5, 1'b1, 1'b0);
    run(8'h70, 12, 1'b1, 1'b0);
    // repeated start instead of stop
    run(8'h13, 3, 1'b0, 1'b1);
    run(8'hC6, 9, 1'b0, 1'b1);
    // protected transfer followed by normal one on same page
    run(8'h2D, 4, 1'b0, 1'b0);

    // R7: requests during a cycle are ignored
    clear_mon(8'h50 / PG);
    pulse_begin(8'h50);
    pulse_byte(8'h11); pulse_byte(8'h22); pulse_byte(8'h33);
    pulse_end(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_begin(8'hA3);
    pulse_byte(8'h99);
    pulse_end(1'b0, 1'b0);
    pulse_end(1'b1, 1'b0);
    repeat (WRC + 4) @(negedge clk);
    chk("R7 busy length", busy_cnt, WRC);
    chk("R7 write count", wr_total, 3);
    chk("R7 pointer", int'(ptr_addr), 8'h53);
    chk("R7 data slot2", int'(cap[2]), 8'h33);

    // R7: byte and stop outside a transfer
    clear_mon(8'h50 / PG);
    pulse_byte(8'h44);
    pulse_end(1'b0, 1'b0);
    repeat (WRC + 4) @(negedge clk);
    chk("R7 idle stop", busy_cnt, 0);
    chk("R7 idle byte pointer", int'(ptr_addr), 8'h53);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule